// File: doc/BRIEF.md
# Partitioned Cache-Way and Memory-Bandwidth Controller

This block shares one cache and one memory port among several software partitions. Every request carries two tags: a partition number and a monitoring-group number. When a partition misses in the cache, the controller picks the way to fill. It only picks from the ways that the partition's way mask allows, and it rotates through them in round-robin order. A partition whose mask is empty is treated as no-allocate: its misses are served from memory and never fill a line. Hits are resolved outside this block, in the tag logic, and any way can hit no matter what the mask says.

Memory-port access is granted one transfer per cycle. Time is divided into a fixed window of WINDOW slots. Each partition has a minimum share and a maximum share, both given as percentages of that window. A partition that has used up its maximum stops receiving grants until the window restarts. Partitions that are still below their minimum are served before all others. Inside a priority tier, the lowest partition number wins.

For each monitoring group there are two saturating counters: one counts cache allocations and one counts bytes transferred. Writing to a group's clear address zeroes both counters of that group. Configuration is written through a small write-only register port.

Top module: `ptnQosTop`

## Requirements
- R1: A write with cfgWe high takes effect at the next clock edge. The address layout is cfgAddr = {kind[1:0], index}. Kind 0 loads the way mask of partition `index` from cfgWdata[NUM_WAYS-1:0]. Kind 1 loads the minimum percentage from cfgWdata[6:0]. Kind 2 loads the maximum percentage from cfgWdata[6:0]. Kind 3 clears monitoring group `index`. After reset, every mask is all ones, every minimum is 0 and every maximum is 100.
- R2: While missValid is high and the mask of missPid is non-zero, allocValid is high in the same cycle. allocWayOh is one-hot and selects the first allowed way after that partition's previous victim, searching cyclically upward. After reset, the search starts at way 0. Each partition keeps its own rotation position.
- R3: A partition whose way mask is all zero never allocates. allocValid stays low, and its miss adds nothing to the allocation counter.
- R4: In each window, a partition receives at most floor(max×WINDOW/100) grants. Windows are WINDOW cycles long, and the first window begins at the first clock edge after reset.
- R5: A requesting partition that has received fewer than floor(min×WINDOW/100) grants in the current window, and is not at its maximum, is granted ahead of every partition that is not below its minimum.
- R6: memGrant is combinational from memReq. It is at most one-hot and only grants a partition that is requesting. Within a priority tier, the lowest-numbered partition wins.
- R7: Each allocation increments the allocation counter of missMid. The counter saturates at 2^CNT_W−1.
- R8: Each grant adds BEAT_BYTES to the byte counter of the monitoring group that the granted partition presents on memReqMid. The counter saturates at 2^CNT_W−1.
- R9: A clear write zeroes both counters of the addressed group. The clear takes priority over an increment in the same cycle.
- R10: When a window ends, the grant usage of every partition returns to zero, so a partition stalled at its maximum is granted again in the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | IDX_W+2 | Write address: {kind, index} |
| cfgWdata | input | CFG_W | Write data |
| missValid | input | 1 | A cache miss needs a victim this cycle |
| missPid | input | PID_W | Partition of the miss |
| missMid | input | MID_W | Monitoring group of the miss |
| allocValid | output | 1 | A fill is allowed |
| allocWayOh | output | NUM_WAYS | One-hot victim way |
| memReq | input | NUM_PART | Per-partition memory request |
| memReqMid | input | NUM_PART*MID_W | Monitoring group of each partition's request |
| memGrant | output | NUM_PART | One-hot memory grant |
| monSel | input | MID_W | Monitoring group to read |
| monAllocCnt | output | CNT_W | Allocation count of monSel |
| monByteCnt | output | CNT_W | Byte count of monSel |

## Verification
The hardest case to reach from the ports is one that depends on window alignment. A maximum or minimum quota only shows up as a grant count over one whole window, and the window phase is never visible at the ports. To get there, the bench keeps its own slot count from reset, waits for slot zero, and then counts grants over exactly one window for each quota setting. The rotation pointer is exercised by sweeping all way masks back to back on one partition, without a reset in between, so each mask starts from wherever the previous one left the pointer.

// File: rtl/ptn_pkg.sv
package ptn_pkg;
  localparam logic [1:0] KIND_MASK = 2'd0;
  localparam logic [1:0] KIND_MIN  = 2'd1;
  localparam logic [1:0] KIND_MAX  = 2'd2;
  localparam logic [1:0] KIND_CLR  = 2'd3;

  typedef struct packed {
    logic wrMask;
    logic wrMin;
    logic wrMax;
    logic clrMon;
    logic winWrap;
  } ptnStrobe_t;
endpackage

// File: rtl/ptnQosCtrl.sv
module ptnQosCtrl import ptn_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2,
  parameter int WINDOW = 100,
  localparam int SLOT_W = $clog2(WINDOW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output ptnStrobe_t        stb,
  output logic [IDX_W-1:0]  cfgIdx
);
  logic [SLOT_W-1:0] slot;
  logic [1:0]        kind;

  // Free-running slot counter that defines the bandwidth window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slot <= '0;
    else if (slot == SLOT_W'(WINDOW - 1)) slot <= '0;
    else slot <= slot + 1'b1;
  end

  always_comb begin
    kind        = cfgAddr[ADDR_W-1 -: 2];
    cfgIdx      = cfgAddr[IDX_W-1:0];
    stb.wrMask  = cfgWe && (kind == KIND_MASK);
    stb.wrMin   = cfgWe && (kind == KIND_MIN);
    stb.wrMax   = cfgWe && (kind == KIND_MAX);
    stb.clrMon  = cfgWe && (kind == KIND_CLR);
    stb.winWrap = (slot == SLOT_W'(WINDOW - 1));
  end
endmodule

// File: rtl/ptnQosData.sv
module ptnQosData import ptn_pkg::*; #(
  parameter int NUM_PART   = 4,
  parameter int NUM_WAYS   = 8,
  parameter int NUM_MON    = 4,
  parameter int WINDOW     = 100,
  parameter int CNT_W      = 12,
  parameter int BEAT_BYTES = 64,
  localparam int PID_W   = $clog2(NUM_PART),
  localparam int MID_W   = $clog2(NUM_MON),
  localparam int IDX_W   = (PID_W > MID_W) ? PID_W : MID_W,
  localparam int CFG_W   = (NUM_WAYS > 7) ? NUM_WAYS : 7,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int USE_W   = $clog2(WINDOW + 1),
  localparam int CNT_MAX = (1 << CNT_W) - 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ptnStrobe_t                stb,
  input  logic [IDX_W-1:0]          cfgIdx,
  input  logic [CFG_W-1:0]          cfgWdata,
  input  logic                      missValid,
  input  logic [PID_W-1:0]          missPid,
  input  logic [MID_W-1:0]          missMid,
  output logic                      allocValid,
  output logic [NUM_WAYS-1:0]       allocWayOh,
  input  logic [NUM_PART-1:0]       memReq,
  input  logic [NUM_PART*MID_W-1:0] memReqMid,
  output logic [NUM_PART-1:0]       memGrant,
  input  logic [MID_W-1:0]          monSel,
  output logic [CNT_W-1:0]          monAllocCnt,
  output logic [CNT_W-1:0]          monByteCnt
);
  logic [NUM_WAYS-1:0] wayMask [NUM_PART];
  logic [6:0]          minPct  [NUM_PART];
  logic [6:0]          maxPct  [NUM_PART];
  logic [WAY_W-1:0]    lastWay [NUM_PART];
  logic [USE_W-1:0]    used    [NUM_PART];
  logic [CNT_W-1:0]    allocCnt[NUM_MON];
  logic [CNT_W-1:0]    byteCnt [NUM_MON];
  logic [NUM_PART-1:0] underMin, atMax, tierHi, tierLo, pickSrc;
  logic [WAY_W-1:0]    victimIdx;
  logic                victimFound;
  logic [PID_W-1:0]    grantIdx;
  logic [MID_W-1:0]    grantMid;
  logic                grantAny;

  function automatic int pctToSlots(input logic [6:0] pct);
    return (int'(pct) * WINDOW) / 100;
  endfunction

  // Per-partition configuration, rotation pointer and window usage.
  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wayMask[p] <= '1;
        minPct[p]  <= 7'd0;
        maxPct[p]  <= 7'd100;
        lastWay[p] <= WAY_W'(NUM_WAYS - 1);
        used[p]    <= '0;
      end else begin
        if (stb.wrMask && int'(cfgIdx) == p) wayMask[p] <= cfgWdata[NUM_WAYS-1:0];
        if (stb.wrMin && int'(cfgIdx) == p)  minPct[p]  <= cfgWdata[6:0];
        if (stb.wrMax && int'(cfgIdx) == p)  maxPct[p]  <= cfgWdata[6:0];
        if (allocValid && int'(missPid) == p) lastWay[p] <= victimIdx;
        if (stb.winWrap) used[p] <= '0;
        else if (memGrant[p]) used[p] <= used[p] + 1'b1;
      end
    end
    assign underMin[p] = int'(used[p]) <  pctToSlots(minPct[p]);
    assign atMax[p]    = int'(used[p]) >= pctToSlots(maxPct[p]);
  end

  // Round-robin victim search among the ways the requester may fill.
  always_comb begin
    victimIdx   = '0;
    victimFound = 1'b0;
    for (int k = 1; k <= NUM_WAYS; k++) begin
      int w;
      w = int'(lastWay[missPid]) + k;
      if (w >= NUM_WAYS) w = w - NUM_WAYS;
      if (!victimFound && wayMask[missPid][w]) begin
        victimFound = 1'b1;
        victimIdx   = WAY_W'(w);
      end
    end
    allocValid = missValid && victimFound;
    allocWayOh = allocValid ? (NUM_WAYS'(1) << victimIdx) : '0;
  end

  // Two-tier fixed-priority memory arbiter.
  always_comb begin
    tierHi   = memReq & ~atMax & underMin;
    tierLo   = memReq & ~atMax;
    pickSrc  = (|tierHi) ? tierHi : tierLo;
    memGrant = '0;
    grantIdx = '0;
    for (int i = NUM_PART - 1; i >= 0; i--) begin
      if (pickSrc[i]) begin
        memGrant    = '0;
        memGrant[i] = 1'b1;
        grantIdx    = PID_W'(i);
      end
    end
    grantAny = |memGrant;
    grantMid = memReqMid[int'(grantIdx)*MID_W +: MID_W];
  end

  // Saturating usage monitors per monitoring group.
  for (genvar m = 0; m < NUM_MON; m++) begin : g_mon
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        allocCnt[m] <= '0;
        byteCnt[m]  <= '0;
      end else if (stb.clrMon && int'(cfgIdx) == m) begin
        allocCnt[m] <= '0;
        byteCnt[m]  <= '0;
      end else begin
        if (allocValid && int'(missMid) == m && int'(allocCnt[m]) != CNT_MAX)
          allocCnt[m] <= allocCnt[m] + 1'b1;
        if (grantAny && int'(grantMid) == m) begin
          if (int'(byteCnt[m]) + BEAT_BYTES > CNT_MAX) byteCnt[m] <= '1;
          else byteCnt[m] <= byteCnt[m] + CNT_W'(BEAT_BYTES);
        end
      end
    end
  end

  assign monAllocCnt = allocCnt[monSel];
  assign monByteCnt  = byteCnt[monSel];
endmodule

// File: rtl/ptnQosTop.sv
module ptnQosTop import ptn_pkg::*; #(
  parameter int NUM_PART   = 4,
  parameter int NUM_WAYS   = 8,
  parameter int NUM_MON    = 4,
  parameter int WINDOW     = 100,
  parameter int CNT_W      = 12,
  parameter int BEAT_BYTES = 64,
  localparam int PID_W  = $clog2(NUM_PART),
  localparam int MID_W  = $clog2(NUM_MON),
  localparam int IDX_W  = (PID_W > MID_W) ? PID_W : MID_W,
  localparam int ADDR_W = IDX_W + 2,
  localparam int CFG_W  = (NUM_WAYS > 7) ? NUM_WAYS : 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWe,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [CFG_W-1:0]          cfgWdata,
  input  logic                      missValid,
  input  logic [PID_W-1:0]          missPid,
  input  logic [MID_W-1:0]          missMid,
  output logic                      allocValid,
  output logic [NUM_WAYS-1:0]       allocWayOh,
  input  logic [NUM_PART-1:0]       memReq,
  input  logic [NUM_PART*MID_W-1:0] memReqMid,
  output logic [NUM_PART-1:0]       memGrant,
  input  logic [MID_W-1:0]          monSel,
  output logic [CNT_W-1:0]          monAllocCnt,
  output logic [CNT_W-1:0]          monByteCnt
);
  ptnStrobe_t       stb;
  logic [IDX_W-1:0] cfgIdx;

  ptnQosCtrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .stb(stb), .cfgIdx(cfgIdx)
  );

  ptnQosData #(
    .NUM_PART(NUM_PART), .NUM_WAYS(NUM_WAYS), .NUM_MON(NUM_MON),
    .WINDOW(WINDOW), .CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgIdx(cfgIdx), .cfgWdata(cfgWdata),
    .missValid(missValid), .missPid(missPid), .missMid(missMid),
    .allocValid(allocValid), .allocWayOh(allocWayOh),
    .memReq(memReq), .memReqMid(memReqMid), .memGrant(memGrant),
    .monSel(monSel), .monAllocCnt(monAllocCnt), .monByteCnt(monByteCnt)
  );
endmodule

// File: rtl/ptnQosChk.sv
module ptnQosChk #(
  parameter int NUM_PART = 4,
  parameter int NUM_WAYS = 8,
  parameter int NUM_MON  = 4,
  parameter int CNT_W    = 12,
  localparam int MID_W   = $clog2(NUM_MON)
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgWe,
  input logic                missValid,
  input logic                allocValid,
  input logic [NUM_WAYS-1:0] allocWayOh,
  input logic [NUM_PART-1:0] memReq,
  input logic [NUM_PART-1:0] memGrant,
  input logic [MID_W-1:0]    monSel,
  input logic [CNT_W-1:0]    monAllocCnt
);
  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memGrant));

  a_r6_grant_requested: assert property (@(posedge clk) disable iff (!rstN)
    (memGrant & ~memReq) == '0);

  a_r2_way_onehot: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |-> $onehot(allocWayOh));

  a_r3_alloc_needs_miss: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |-> missValid);

  a_r7_count_no_drop: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> (monSel != $past(monSel) || monAllocCnt >= $past(monAllocCnt)));

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWe && !missValid) |=> (monSel != $past(monSel) || monAllocCnt == $past(monAllocCnt)));
endmodule

bind ptnQosTop ptnQosChk #(
  .NUM_PART(NUM_PART), .NUM_WAYS(NUM_WAYS), .NUM_MON(NUM_MON), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .missValid(missValid),
  .allocValid(allocValid), .allocWayOh(allocWayOh), .memReq(memReq),
  .memGrant(memGrant), .monSel(monSel), .monAllocCnt(monAllocCnt)
);

// File: tb/tb_ptnQosTop.sv
module tb_ptnQosTop;
  localparam int NP = 4, NW = 8, NM = 4, WIN = 100, CW = 12, BB = 64;
  localparam int CMAX = (1 << CW) - 1;

  logic       clk = 1'b0, rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [7:0] cfgWdata = '0;
  logic       missValid = 1'b0;
  logic [1:0] missPid = '0, missMid = '0;
  logic       allocValid;
  logic [7:0] allocWayOh;
  logic [3:0] memReq = '0;
  logic [7:0] memReqMid = {2'd3, 2'd2, 2'd1, 2'd0};
  logic [3:0] memGrant;
  logic [1:0] monSel = '0;
  logic [CW-1:0] monAllocCnt, monByteCnt;

  int errors = 0, checks = 0, cycles = 0, slotModel = 0;
  int lastModel [NP];
  int gOf [WIN];

  always #4 clk = ~clk;

  ptnQosTop dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) slotModel <= 0;
    else slotModel <= (slotModel == WIN - 1) ? 0 : slotModel + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    for (int p = 0; p < NP; p++) lastModel[p] = NW - 1;
  endtask

  task automatic cfgWrite(input int kind, input int idx, input int data);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'((kind << 2) | idx); cfgWdata = 8'(data);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic int nextWay(input int mask, input int last);
    for (int k = 1; k <= NW; k++) begin
      int w;
      w = (last + k) % NW;
      if (mask[w]) return w;
    end
    return -1;
  endfunction

  function automatic int ohIdx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  // One miss: drive at a negedge, sample after settling, clocked at next edge.
  task automatic oneMiss(input int pid, input int mid, input int mask, input string req);
    int expW;
    @(negedge clk);
    missValid = 1'b1; missPid = 2'(pid); missMid = 2'(mid);
    #1;
    expW = nextWay(mask, lastModel[pid]);
    chk(req, int'(allocValid), (expW >= 0) ? 1 : 0);
    if (expW >= 0) begin
      chk(req, ohIdx(allocWayOh), expW);
      lastModel[pid] = expW;
    end
    @(negedge clk);
    missValid = 1'b0;
  endtask

  // Run exactly one aligned window, recording the granted partition per slot.
  task automatic runWindow(input logic [3:0] reqs);
    @(negedge clk);
    while (slotModel != 0) @(negedge clk);
    memReq = reqs;
    for (int s = 0; s < WIN; s++) begin
      #1;
      gOf[s] = ohIdx({4'b0, memGrant});
      @(negedge clk);
    end
    memReq = '0;
  endtask

  function automatic int countOf(input int p, input int upTo);
    int n = 0;
    for (int s = 0; s < upTo; s++) if (gOf[s] == p) n++;
    return n;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    doReset();
    // Reset state (R1)
    #1;
    chk("R1 reset grant", int'(memGrant), 0);
    chk("R1 reset allocValid", int'(allocValid), 0);
    chk("R1 reset alloc cnt", int'(monAllocCnt), 0);
    chk("R1 reset byte cnt", int'(monByteCnt), 0);
    oneMiss(0, 0, 8'hFF, "R1 default mask first victim way0");

    // Sweep every mask value on partition 1, nine misses each (R2, R3)
    for (int mask = 0; mask < 256; mask++) begin
      cfgWrite(0, 1, mask);
      for (int k = 0; k < 9; k++)
        oneMiss(1, 1, mask, (mask == 0) ? "R3 zero mask no alloc" : "R2 round-robin victim");
    end
    // Partition 2 rotation untouched by partition 1 (R2)
    oneMiss(2, 2, 8'hFF, "R2 independent pointer");
    @(negedge clk); monSel = 2'd1; #1;
    chk("R7 R3 alloc count mid1", int'(monAllocCnt), 255 * 9);
    monSel = 2'd2; #1;
    chk("R7 alloc count mid2", int'(monAllocCnt), 1);

    // Clear of group 1 (R9)
    cfgWrite(3, 1, 0);
    monSel = 2'd1; #1;
    chk("R9 clear alloc", int'(monAllocCnt), 0);
    monSel = 2'd2; #1;
    chk("R9 other group kept", int'(monAllocCnt), 1);

    // Allocation counter saturation (R7)
    cfgWrite(0, 3, 8'hFF);
    for (int n = 0; n < CMAX + 5; n++) begin
      @(negedge clk); missValid = 1'b1; missPid = 2'd3; missMid = 2'd3;
    end
    @(negedge clk); missValid = 1'b0; monSel = 2'd3; #1;
    chk("R7 alloc saturation", int'(monAllocCnt), CMAX);

    // Maximum share sweep on one partition (R4, R10)
    doReset();
    foreach (gOf[i]) gOf[i] = -1;
    begin
      int maxVals[5] = '{0, 1, 37, 99, 100};
      foreach (maxVals[i]) begin
        cfgWrite(2, 2, maxVals[i]);
        runWindow(4'b0100);
        chk("R4 R10 max share grants", countOf(2, WIN), (maxVals[i] * WIN) / 100);
      end
    end

    // Two partitions, lower index capped at 30% (R4, R6)
    cfgWrite(2, 0, 30);
    runWindow(4'b0011);
    chk("R6 lowest index first", gOf[0], 0);
    chk("R4 capped partition", countOf(0, WIN), 30);
    chk("R6 other takes rest", countOf(1, WIN), 70);

    // Minimum share priority and byte counters (R5, R8)
    cfgWrite(2, 0, 100);
    cfgWrite(1, 3, 20);
    cfgWrite(3, 0, 0);
    cfgWrite(3, 3, 0);
    runWindow(4'b1001);
    chk("R5 min partition first 20", countOf(3, 20), 20);
    chk("R5 min partition total", countOf(3, WIN), 20);
    chk("R5 other partition total", countOf(0, WIN), 80);
    @(negedge clk); monSel = 2'd3; #1;
    chk("R8 bytes mid3", int'(monByteCnt), 20 * BB);
    monSel = 2'd0; #1;
    chk("R8 bytes saturate mid0", int'(monByteCnt), CMAX);
    cfgWrite(3, 0, 0);
    #1;
    chk("R9 clear bytes", int'(monByteCnt), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule